// File: doc/BRIEF.md
# Single-Clock Dual-Port RAM with Optional Write Forwarding

A synchronous storage array with one write port and one read port, both on a single clock, for use as cache data storage. Each port carries its own address. A write stores its word on the rising clock edge. A read is registered, so the word appears on the output one edge after the read is requested. Between reads the output keeps its last value.

A build-time parameter sets how a collision behaves. A collision is a write and a read to the same address in the same cycle. With forwarding on, the word being written goes straight to the read output. With forwarding off, the read returns the word that was stored before the write (read-before-write). Address and data widths are parameters. The depth is two to the power of the address width. The stored words are not reset; only the output register is.

Top module: `sdp_ram`

## Requirements
- R1: While `rst_ni` is low, `rd_data_o` is 0, whatever the other inputs do.
- R2: When `rd_en_i` is high at a rising edge and there is no collision, `rd_data_o` after that edge equals the word stored at `rd_addr_i` by earlier edges.
- R3: When `rd_en_i` is low at a rising edge, `rd_data_o` keeps its value across that edge, even if a write happens.
- R4: When `wr_en_i` is high at a rising edge, `wr_data_i` is stored at `wr_addr_i`, whether or not a read happens in the same cycle.
- R5: With `FWD_EN` = 1, a collision (both enables high and `wr_addr_i` == `rd_addr_i`) makes `rd_data_o` after the edge equal `wr_data_i`.
- R6: With `FWD_EN` = 0, a collision makes `rd_data_o` after the edge equal the word stored before that edge. The new word is visible to later reads.
- R7: A write to one address does not change what a read of a different address returns in the same cycle.
- R8: The array has 2**`ADDR_W` independent words: address 0 and address 2**`ADDR_W`-1 hold distinct values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output register |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Registered read word |

## Verification
A corrupted stored word only shows up when that address is read. The error then appears on `rd_data_o` one edge after the read, so the bench first writes every address and then reads all of them many times. A fault in the output hold or in forwarding appears at the very next edge, either as a change with no read or as a wrong collision value. Two instances, one per parameter setting, are driven from the same stimulus, so the two collision rules are told apart on the same cycle.

// File: rtl/sdp_ram_pkg.sv
package sdp_ram_pkg;
  function automatic int unsigned depth_of(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/sdp_ram_array.sv
module sdp_ram_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // pre-edge contents: gives read-before-write on collision
  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/sdp_ram_rd.sv
module sdp_ram_rd #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] stored_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] next_word;
  logic [DATA_W-1:0] data_q;

  if (FWD_EN) begin : g_fwd
    logic hit;
    assign hit       = wr_en_i && (wr_addr_i == rd_addr_i);
    assign next_word = hit ? wr_data_i : stored_i;
  end else begin : g_nofwd
    logic unused_wr;
    assign unused_wr = ^{wr_en_i, wr_addr_i, wr_data_i};
    assign next_word = stored_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_en_i) data_q <= next_word;
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/sdp_ram.sv
module sdp_ram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = sdp_ram_pkg::depth_of(ADDR_W);

  logic [DATA_W-1:0] stored_word;

  sdp_ram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_word_o (stored_word)
  );

  sdp_ram_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FWD_EN(FWD_EN)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .stored_i  (stored_word),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/sdp_ram_chk.sv
module sdp_ram_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter bit          FWD_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o
);
  p_rst_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rd_data_o == '0));

  p_change_needs_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> $past(rd_en_i));

  p_hold_no_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  if (FWD_EN) begin : g_fwd
    p_fwd_collision_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && wr_en_i && (wr_addr_i == rd_addr_i)) |=> (rd_data_o == $past(wr_data_i)));
  end
endmodule

bind sdp_ram sdp_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FWD_EN(FWD_EN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/sdp_ram_tb.sv
`timescale 1ns/1ps
module sdp_ram_tb;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] dout_f, dout_n;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_f = '0, exp_n = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdp_ram #(.ADDR_W(AW), .DATA_W(DW), .FWD_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(dout_f));

  sdp_ram #(.ADDR_W(AW), .DATA_W(DW), .FWD_EN(1'b0)) u_dut_nofwd (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(dout_n));

  function automatic logic [DW-1:0] model_fwd(input logic [DW-1:0] prev);
    if (!re) return prev;
    if (we && wa == ra) return wd;
    return ref_mem[ra];
  endfunction

  function automatic logic [DW-1:0] model_rbw(input logic [DW-1:0] prev);
    if (!re) return prev;
    return ref_mem[ra];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, update model, sample 1 ns after the rising edge
  task automatic step(input logic w, input logic [AW-1:0] a_w, input logic [DW-1:0] d,
                      input logic r, input logic [AW-1:0] a_r, input string tag_f, input string tag_n);
    @(negedge clk);
    we = w; wa = a_w; wd = d; re = r; ra = a_r;
    exp_f = model_fwd(exp_f);
    exp_n = model_rbw(exp_n);
    if (w) ref_mem[a_w] = d;
    @(posedge clk);
    #1;
    check(tag_f, dout_f, exp_f);
    check(tag_n, dout_n, exp_n);
  endtask

  task automatic auto_step(input logic w, input logic [AW-1:0] a_w, input logic [DW-1:0] d,
                           input logic r, input logic [AW-1:0] a_r);
    if (!r)                  step(w, a_w, d, r, a_r, "R3 hold", "R3 hold");
    else if (w && a_w == a_r) step(w, a_w, d, r, a_r, "R5 forward", "R6 read-before-write");
    else if (w)              step(w, a_w, d, r, a_r, "R7 other addr", "R7 other addr");
    else                     step(w, a_w, d, r, a_r, "R2 read", "R2 read");
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    // R1: reset holds output at 0 even with a read and write requested
    we = 1'b1; wa = 4'd3; wd = 16'hdead; re = 1'b1; ra = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset fwd", dout_f, '0);
    check("R1 reset rbw", dout_n, '0);
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    rst_n = 1'b1;
    // write every address, reads off (R4, R3)
    for (int i = 0; i < DEPTH; i++) auto_step(1'b1, AW'(i), DW'(16'h1000 + i * 16'h0111), 1'b0, '0);
    // R8: extremes hold distinct values
    auto_step(1'b1, '0, 16'h0a0a, 1'b0, '0);
    auto_step(1'b1, AW'(DEPTH - 1), 16'hf5f5, 1'b0, '0);
    step(1'b0, '0, '0, 1'b1, '0, "R8 low addr", "R8 low addr");
    step(1'b0, '0, '0, 1'b1, AW'(DEPTH - 1), "R8 high addr", "R8 high addr");
    // R4: write while reading elsewhere, then read back
    auto_step(1'b1, 4'd5, 16'h5555, 1'b1, 4'd6);
    step(1'b0, '0, '0, 1'b1, 4'd5, "R4 write during read", "R4 write during read");
    // collisions: R5 / R6, then new word visible to later read (R6)
    auto_step(1'b1, 4'd7, 16'hbeef, 1'b1, 4'd7);
    step(1'b0, '0, '0, 1'b1, 4'd7, "R6 later read fwd", "R6 later read");
    auto_step(1'b1, 4'd7, 16'hcafe, 1'b1, 4'd7);
    // R3: hold across writes, including to the last-read address
    auto_step(1'b1, 4'd7, 16'h1111, 1'b0, 4'd7);
    auto_step(1'b1, 4'd2, 16'h2222, 1'b0, 4'd2);
    // random mix, with forced collisions
    for (int i = 0; i < 3000; i++) begin
      logic          w, r;
      logic [AW-1:0] aw, ar;
      w  = ($urandom % 3) != 0;
      r  = ($urandom % 4) != 0;
      aw = AW'($urandom % DEPTH);
      ar = (($urandom % 4) == 0) ? aw : AW'($urandom % DEPTH);
      auto_step(w, aw, DW'($urandom), r, ar);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule